// File: doc/BRIEF.md
# Flash Emulation RAM Overlay Remapper

This block sits on the CPU bus of a microcontroller with on-chip flash and RAM. It lets a fixed 1 KB slice of RAM stand in for one of the four small 1 KB flash erase blocks at the bottom of the address map. Firmware can then tune data or code in RAM at the flash address before committing it to flash. A small control register holds an overlay enable bit and a 3-bit block select. Every bus address is decoded combinationally and sent to flash or to RAM, together with a remapped physical address and the 10-bit offset inside the 1 KB window.

While the overlay is enabled, the block also gates the flash program and erase mode requests. Program mode and erase mode are held off for every flash block, whichever block is overlaid. Clearing the enable bit releases the overlay and the protection together, starting with the next bus cycle. The RAM slice stays reachable at its own address the whole time.

Top module: `ovl_remap_top`

## Requirements
- R1: After synchronous reset the control register reads 0x00, no overlay is active, and the program/erase requests pass straight through.
- R2: The control register keeps the enable bit at bit 3 and the block select at bits 2:0. Bits 7:4 always read 0 and ignore writes. A write becomes visible on the cycle after the clock edge that captures it.
- R3: With the enable bit clear, a valid address below 0x020000 asserts flash_sel only, with mem_addr equal to the bus address.
- R4: With the enable bit set and select 0..3, a valid address inside flash block k (start k*0x400, 1 KB long) for k equal to the select asserts ram_sel and overlay_hit, with mem_addr = 0xFFE000 + (address mod 0x400).
- R5: Select values 4..7 overlay block 0.
- R6: With the enable bit set, flash addresses outside the selected block, including the other small blocks and everything from 0x001000 up, still go to flash unchanged.
- R7: A valid address in RAM (0xFFE000 to 0xFFEFBF) asserts ram_sel with mem_addr unchanged, whatever the register holds. This keeps the slice 0xFFE000 to 0xFFE3FF reachable at its own address.
- R8: pgm_mode = pgm_bit AND NOT enable and ers_mode = ers_bit AND NOT enable, for every select value.
- R9: Clearing the enable bit sends the selected block address back to flash and lets program/erase requests through, starting on the first cycle after the write.
- R10: With bus_valid low, or with an address outside both flash and RAM, neither strobe is asserted. win_offset always equals the low 10 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read data |
| bus_valid | input | 1 | Bus access in progress |
| bus_addr | input | 24 | CPU byte address |
| flash_sel | output | 1 | Access goes to the flash array |
| ram_sel | output | 1 | Access goes to the RAM array |
| overlay_hit | output | 1 | Access was redirected from flash to the RAM slice |
| mem_addr | output | 24 | Physical address after remapping |
| win_offset | output | 10 | Offset within the 1 KB window |
| pgm_bit | input | 1 | Program request from the flash control register |
| ers_bit | input | 1 | Erase request from the flash control register |
| pgm_mode | output | 1 | Effective program mode |
| ers_mode | output | 1 | Effective erase mode |

## Verification
A register write that toggles the enable bit can land in the same cycle as a bus access to the overlaid block and an active program or erase request. The bench holds the address inside the selected block with pgm_bit and ers_bit high while it writes the register. Before the capturing edge it expects the old routing and gating. After the edge it expects the new routing, and the mode outputs flip in the same cycle as the routing. Both are judged against a model of the address map evaluated in the bench for every register value and a sweep of block-boundary addresses.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int ADDR_W      = 24;
    localparam int WIN_W       = 10;
    localparam int NUM_BLK     = 4;
    localparam int SEL_W       = 3;
    localparam int REG_W       = 8;
    localparam int FLASH_BYTES = 32'h0002_0000;
    localparam int RAM_BASE    = 32'h00FF_E000;
    localparam int RAM_BYTES   = 32'h0000_0FC0;
    localparam int EN_POS      = 3;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ovl_cfg_t;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_RAM   = 2'd2,
        TGT_OVL   = 2'd3
    } ovl_tgt_e;
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
    import ovl_pkg::*;
#(
    parameter int NBLK = NUM_BLK,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             en,
    output logic [BLK_W-1:0] tgt_blk
);
    ovl_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.en  <= wr_data[EN_POS];
            cfg_q.sel <= wr_data[SEL_W-1:0];
        end
    end

    always_comb begin
        rd_data                = '0;
        rd_data[EN_POS]        = cfg_q.en;
        rd_data[SEL_W-1:0]     = cfg_q.sel;
    end

    assign en = cfg_q.en;

    // out-of-range selects fall back to block 0
    always_comb begin
        if ({1'b0, cfg_q.sel} < (SEL_W+1)'(NBLK))
            tgt_blk = cfg_q.sel[BLK_W-1:0];
        else
            tgt_blk = '0;
    end
endmodule

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode
    import ovl_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int WW    = WIN_W,
    parameter int NBLK  = NUM_BLK,
    parameter int FL_SZ = FLASH_BYTES,
    parameter int RM_LO = RAM_BASE,
    parameter int RM_SZ = RAM_BYTES,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             valid,
    input  logic [AW-1:0]    addr,
    input  logic             en,
    input  logic [BLK_W-1:0] tgt_blk,
    output logic             flash_sel,
    output logic             ram_sel,
    output logic             hit,
    output logic [AW-1:0]    mem_addr,
    output logic [WW-1:0]    offset
);
    localparam logic [AW-1:0] FLASH_LIM = AW'(FL_SZ);
    localparam logic [AW-1:0] RAM_START = AW'(RM_LO);
    localparam logic [AW-1:0] RAM_LIM   = AW'(RM_LO + RM_SZ);

    logic [NBLK-1:0] blk_match;
    logic            in_flash;
    logic            in_ram;
    ovl_tgt_e        tgt;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        assign blk_match[k] = (addr[AW-1:WW] == (AW-WW)'(k));
    end

    assign in_flash = (addr < FLASH_LIM);
    assign in_ram   = (addr >= RAM_START) && (addr < RAM_LIM);

    always_comb begin
        if (!valid)                    tgt = TGT_NONE;
        else if (en && blk_match[tgt_blk]) tgt = TGT_OVL;
        else if (in_ram)               tgt = TGT_RAM;
        else if (in_flash)             tgt = TGT_FLASH;
        else                           tgt = TGT_NONE;
    end

    assign flash_sel = (tgt == TGT_FLASH);
    assign ram_sel   = (tgt == TGT_RAM) || (tgt == TGT_OVL);
    assign hit       = (tgt == TGT_OVL);
    assign offset    = addr[WW-1:0];
    assign mem_addr  = (tgt == TGT_OVL) ? {RAM_START[AW-1:WW], addr[WW-1:0]} : addr;
endmodule

// File: rtl/ovl_prot_gate.sv
module ovl_prot_gate (
    input  logic en,
    input  logic pgm_bit,
    input  logic ers_bit,
    output logic pgm_mode,
    output logic ers_mode
);
    assign pgm_mode = pgm_bit & ~en;
    assign ers_mode = ers_bit & ~en;
endmodule

// File: rtl/ovl_remap_top.sv
module ovl_remap_top
    import ovl_pkg::*;
#(
    parameter int NBLK  = NUM_BLK,
    parameter int FL_SZ = FLASH_BYTES,
    parameter int RM_LO = RAM_BASE,
    parameter int RM_SZ = RAM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wr_data,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              flash_sel,
    output logic              ram_sel,
    output logic              overlay_hit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WIN_W-1:0]  win_offset,
    input  logic              pgm_bit,
    input  logic              ers_bit,
    output logic              pgm_mode,
    output logic              ers_mode
);
    localparam int BLK_W = $clog2(NBLK);

    logic             en;
    logic [BLK_W-1:0] tgt_blk;

    ovl_ctrl_reg #(.NBLK(NBLK)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .en      (en),
        .tgt_blk (tgt_blk)
    );

    ovl_addr_decode #(
        .AW(ADDR_W), .WW(WIN_W), .NBLK(NBLK),
        .FL_SZ(FL_SZ), .RM_LO(RM_LO), .RM_SZ(RM_SZ)
    ) u_dec (
        .valid     (bus_valid),
        .addr      (bus_addr),
        .en        (en),
        .tgt_blk   (tgt_blk),
        .flash_sel (flash_sel),
        .ram_sel   (ram_sel),
        .hit       (overlay_hit),
        .mem_addr  (mem_addr),
        .offset    (win_offset)
    );

    ovl_prot_gate u_gate (
        .en       (en),
        .pgm_bit  (pgm_bit),
        .ers_bit  (ers_bit),
        .pgm_mode (pgm_mode),
        .ers_mode (ers_mode)
    );
endmodule

// File: rtl/ovl_remap_chk.sv
module ovl_remap_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [7:0]  reg_wr_data,
    input logic [7:0]  reg_rd_data,
    input logic        bus_valid,
    input logic        flash_sel,
    input logic        ram_sel,
    input logic        overlay_hit,
    input logic        pgm_mode,
    input logic        ers_mode
);
    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[7:4] == 4'h0);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> reg_rd_data[3:0] == $past(reg_wr_data[3:0]));

    // R8
    prot_block_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[3] |-> (!pgm_mode && !ers_mode));

    // R4
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        overlay_hit |-> (ram_sel && reg_rd_data[3]));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (!flash_sel && !ram_sel));

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        !(flash_sel && ram_sel));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_rd_data[3]) |-> !overlay_hit);
endmodule

bind ovl_remap_top ovl_remap_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .bus_valid   (bus_valid),
    .flash_sel   (flash_sel),
    .ram_sel     (ram_sel),
    .overlay_hit (overlay_hit),
    .pgm_mode    (pgm_mode),
    .ers_mode    (ers_mode)
);

// File: tb/tb_ovl_remap_top.sv
module tb_ovl_remap_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic [7:0]  reg_rd_data;
    logic        bus_valid;
    logic [23:0] bus_addr;
    logic        flash_sel, ram_sel, overlay_hit;
    logic [23:0] mem_addr;
    logic [9:0]  win_offset;
    logic        pgm_bit, ers_bit, pgm_mode, ers_mode;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ovl_remap_top dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] addr_at(input int i);
        case (i)
            0: return 24'h000000;  1: return 24'h0003FF;  2: return 24'h000400;
            3: return 24'h0005A5;  4: return 24'h0007FF;  5: return 24'h000800;
            6: return 24'h000BFF;  7: return 24'h000C00;  8: return 24'h000FFF;
            9: return 24'h001000; 10: return 24'h01FFFF; 11: return 24'h020000;
           12: return 24'hFFDFFF; 13: return 24'hFFE000; 14: return 24'hFFE3FF;
           15: return 24'hFFE400; 16: return 24'hFFEFBF; 17: return 24'hFFEFC0;
           18: return 24'h800123; default: return 24'h000A5A;
        endcase
    endfunction

    // drive at negedge, then write through one posedge
    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = 8'hFF;
    endtask

    task automatic probe(input bit en, input int sel, input logic [23:0] a, input bit v);
        int  blk;
        bit  hit, in_fl, in_rm, e_fl, e_rm;
        logic [23:0] e_mem;
        string tag;
        bus_addr = a; bus_valid = v;
        #1;
        blk   = (sel < 4) ? sel : 0;
        in_fl = a < 24'h020000;
        in_rm = (a >= 24'hFFE000) && (a < 24'hFFEFC0);
        hit   = v && en && ((a >> 10) == blk);
        e_rm  = v && (hit || in_rm);
        e_fl  = v && in_fl && !hit;
        e_mem = hit ? (24'hFFE000 | {14'd0, a[9:0]}) : a;
        if (!v || (!in_fl && !in_rm)) tag = "R10";
        else if (hit) tag = (sel >= 4) ? "R5" : "R4";
        else if (in_rm) tag = "R7";
        else if (en) tag = "R6";
        else tag = "R3";
        chk({flash_sel, ram_sel, overlay_hit} == {e_fl, e_rm, hit}, {tag, " strobes"},
            {flash_sel, ram_sel, overlay_hit}, {e_fl, e_rm, hit});
        chk(mem_addr == e_mem, {tag, " mem_addr"}, mem_addr, e_mem);
        chk(win_offset == a[9:0], "R10 offset", win_offset, a[9:0]);
        @(negedge clk);
    endtask

    initial begin
        #150000;
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
        bus_valid = 1'b0; bus_addr = 24'h0; pgm_bit = 1'b0; ers_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        pgm_bit = 1'b1; ers_bit = 1'b1; bus_valid = 1'b1; bus_addr = 24'h000000;
        #1;
        chk(reg_rd_data == 8'h00, "R1 reg", reg_rd_data, 0);
        chk({pgm_mode, ers_mode} == 2'b11, "R1 modes", {pgm_mode, ers_mode}, 3);
        chk({flash_sel, overlay_hit} == 2'b10, "R1 no overlay", {flash_sel, overlay_hit}, 2);
        @(negedge clk);

        for (int c = 0; c < 16; c++) begin
            wr_reg({4'hF ^ c[3:0], c[3:0]});
            #1;
            chk(reg_rd_data == {4'h0, c[3:0]}, "R2 readback", reg_rd_data, c);
            @(negedge clk);
            for (int i = 0; i < 20; i++) probe(c[3], c & 7, addr_at(i), 1'b1);
            probe(c[3], c & 7, 24'h000000, 1'b0);
            for (int m = 0; m < 4; m++) begin
                pgm_bit = m[0]; ers_bit = m[1];
                #1;
                chk(pgm_mode == (m[0] & ~c[3]), "R8 pgm", pgm_mode, m[0] & ~c[3]);
                chk(ers_mode == (m[1] & ~c[3]), "R8 ers", ers_mode, m[1] & ~c[3]);
                @(negedge clk);
            end
        end

        // R9 same-cycle: access to overlaid block 2 with requests high while enable clears
        pgm_bit = 1'b1; ers_bit = 1'b1;
        wr_reg(8'h0A);
        bus_valid = 1'b1; bus_addr = 24'h000812;
        reg_wr_en = 1'b1; reg_wr_data = 8'h02;
        #1;
        chk(overlay_hit && mem_addr == 24'hFFE012, "R9 before edge", mem_addr, 24'hFFE012);
        chk(!pgm_mode && !ers_mode, "R9 before edge prot", {pgm_mode, ers_mode}, 0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
        chk(flash_sel && !overlay_hit && mem_addr == 24'h000812, "R9 released",
            mem_addr, 24'h000812);
        chk(pgm_mode && ers_mode, "R9 prot released", {pgm_mode, ers_mode}, 3);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule